// File: doc/BRIEF.md
# Iterative Rotation-Mode CORDIC Sine/Cosine Unit

This block turns a signed fixed-point angle into its cosine and sine without any multiplier. A one-cycle `start_i` hands it an angle. The unit then runs one shift-and-add micro-rotation per clock for a fixed number of steps and presents both results on registered outputs, together with a single-cycle `done_o` strobe.

The rotation direction of each step follows the sign of the remaining angle. The fixed CORDIC gain is cancelled once, by seeding the x coordinate with the reciprocal gain rather than scaling the result. Angles whose magnitude exceeds a quarter turn are first turned by half a turn, with the seed vector negated, so every angle code converges. Internally the coordinates and the residual angle carry guard bits beyond the output width.

Top module: `cordic_rot`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `busy_o` and `done_o` are 0 and both `cos_o` and `sin_o` read 0.
- R2: A `start_i` sampled while the unit is idle raises `busy_o` on the next cycle. `busy_o` then stays high for exactly 16 cycles.
- R3: `done_o` is high for exactly one cycle, the cycle right after `busy_o` falls, and is never high together with `busy_o`.
- R4: A `start_i` sampled while `busy_o` is high is ignored. The running computation keeps its timing and its angle. A `start_i` sampled in the `done_o` cycle is accepted.
- R5: The angle is captured only on the accepted `start_i`. Changes on `angle_i` during the run do not alter the result.
- R6: The angle is a 16-bit two's-complement number in which one LSB is pi/32768: 0x4000 is +pi/2 and 0x8000 is -pi. `cos_o` and `sin_o` are 16-bit two's-complement with 14 fraction bits, so 0x4000 means 1.0. When `done_o` is high, each output is within 8 LSB of the rounded true value.
- R7: Angles with magnitude above pi/2 (codes above 0x4000 or below 0xC000, read as signed) meet the same R6 accuracy, the extreme codes 0x7FFF and 0x8000 included.
- R8: `cos_o` and `sin_o` change only on the cycle where `done_o` is high, and hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a computation when idle |
| angle_i | input | 16 | Signed angle, LSB = pi/32768 |
| busy_o | output | 1 | Micro-rotations in progress |
| done_o | output | 1 | One-cycle strobe: results updated |
| cos_o | output | 16 | Cosine, signed, 14 fraction bits |
| sin_o | output | 16 | Sine, signed, 14 fraction bits |

## Verification
The assertions assume that `start_i` and `angle_i` change only away from the rising edge. They also assume that reset is held for at least two cycles, so that no past value they compare against is unknown.

Every angle code is legal. The stimulus therefore sweeps the whole circle, including both quarter-turn boundaries and the two extreme codes, and drives all inputs on the falling edge.

The norm and residual assertions depend on the constant table and the gain seed being consistent for 16 steps. They would flag a wrong shift or a wrong direction choice even where the bench tolerance still admits the output.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    parameter int OUT_W = 16;
    parameter int ANG_W = 16;
    parameter int ITERS = 16;
    parameter int GUARD = 3;

    localparam int XY_W   = OUT_W + GUARD;
    localparam int FRAC_W = OUT_W - 2 + GUARD;
    localparam int Z_W    = ANG_W + GUARD;
    localparam int STEP_W = (ITERS > 1) ? $clog2(ITERS) : 1;
    localparam real PI_R  = 3.14159265358979323846;

    typedef logic signed [XY_W-1:0] xy_t;
    typedef logic signed [Z_W-1:0]  zres_t;
    typedef logic signed [ANG_W-1:0] ang_t;
    typedef logic [STEP_W-1:0]      step_t;

    typedef struct packed {
        xy_t   x;
        xy_t   y;
        zres_t z;
    } rot_vec_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam zres_t QUARTER_Z = zres_t'(1) <<< (ANG_W - 2 + GUARD);
    localparam zres_t RES_TOL   = zres_t'(32);

    function automatic zres_t atan_const(input int j);
        real r;
        r = $atan(2.0 ** (-j)) / PI_R * (2.0 ** (ANG_W - 1 + GUARD));
        return zres_t'($rtoi(r + 0.5));
    endfunction

    function automatic xy_t gain_seed();
        real k;
        k = 1.0;
        for (int j = 0; j < ITERS; j++) begin
            k = k / $sqrt(1.0 + 2.0 ** (-2 * j));
        end
        return xy_t'($rtoi(k * (2.0 ** FRAC_W) + 0.5));
    endfunction

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom
    import cordic_pkg::*;
(
    input  step_t idx,
    output zres_t atan_o
);
    zres_t tbl [ITERS];

    for (genvar j = 0; j < ITERS; j++) begin : g_entry
        localparam zres_t C = atan_const(j);
        assign tbl[j] = C;
    end

    always_comb begin
        atan_o = '0;
        for (int k = 0; k < ITERS; k++) begin
            if (int'(idx) == k) begin
                atan_o = tbl[k];
            end
        end
    end
endmodule

// File: rtl/cordic_prerot.sv
module cordic_prerot
    import cordic_pkg::*;
(
    input  ang_t     angle,
    output rot_vec_t seed
);
    localparam ang_t QUARTER_A = ang_t'(1) <<< (ANG_W - 2);
    localparam xy_t  K_SEED    = gain_seed();

    logic  flip;
    ang_t  folded;

    always_comb begin
        flip   = (angle > QUARTER_A) || (angle < -QUARTER_A);
        folded = angle;
        if (flip) begin
            folded[ANG_W-1] = ~angle[ANG_W-1];
        end
        seed.x = flip ? -K_SEED : K_SEED;
        seed.y = '0;
        seed.z = zres_t'(folded) <<< GUARD;
    end
endmodule

// File: rtl/cordic_stage.sv
module cordic_stage
    import cordic_pkg::*;
(
    input  rot_vec_t cur,
    input  step_t    j,
    input  zres_t    atan_j,
    output rot_vec_t nxt
);
    xy_t  x_sh;
    xy_t  y_sh;
    logic pos;

    always_comb begin
        x_sh = cur.x >>> j;
        y_sh = cur.y >>> j;
        pos  = ~cur.z[Z_W-1];
        if (pos) begin
            nxt.x = cur.x - y_sh;
            nxt.y = cur.y + x_sh;
            nxt.z = cur.z - atan_j;
        end else begin
            nxt.x = cur.x + y_sh;
            nxt.y = cur.y - x_sh;
            nxt.z = cur.z + atan_j;
        end
    end
endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
    import cordic_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  busy,
    output logic  done,
    output logic  load,
    output logic  last,
    output step_t step
);
    localparam step_t LAST_STEP = step_t'(ITERS - 1);

    run_state_e state;

    assign busy = (state == ST_RUN);
    assign load = start && (state == ST_IDLE);
    assign last = busy && (step == LAST_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
            done  <= 1'b0;
        end else begin
            done <= last;
            if (load) begin
                state <= ST_RUN;
                step  <= '0;
            end else if (last) begin
                state <= ST_IDLE;
                step  <= '0;
            end else if (busy) begin
                step <= step + 1'b1;
            end
        end
    end

    a_r2_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && step == '0));

    a_r2_run_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(step) == LAST_STEP));

    a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && step != LAST_STEP) |=> (busy && step == step_t'($past(step) + 1'b1)));
endmodule

// File: rtl/cordic_rot.sv
module cordic_rot
    import cordic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [ANG_W-1:0] angle_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [OUT_W-1:0] cos_o,
    output logic [OUT_W-1:0] sin_o
);
    localparam xy_t HALF_LSB = xy_t'(1) <<< (GUARD - 1);

    rot_vec_t seed;
    rot_vec_t acc;
    rot_vec_t nxt;
    zres_t    atan_j;
    step_t    step;
    logic     load;
    logic     last;
    xy_t      x_rnd;
    xy_t      y_rnd;

    cordic_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .busy  (busy_o),
        .done  (done_o),
        .load  (load),
        .last  (last),
        .step  (step)
    );

    cordic_prerot u_prerot (
        .angle (ang_t'(angle_i)),
        .seed  (seed)
    );

    cordic_atan_rom u_rom (
        .idx    (step),
        .atan_o (atan_j)
    );

    cordic_stage u_stage (
        .cur    (acc),
        .j      (step),
        .atan_j (atan_j),
        .nxt    (nxt)
    );

    assign x_rnd = nxt.x + HALF_LSB;
    assign y_rnd = nxt.y + HALF_LSB;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc   <= '0;
            cos_o <= '0;
            sin_o <= '0;
        end else begin
            if (load) begin
                acc <= seed;
            end else if (busy_o) begin
                acc <= nxt;
            end
            if (last) begin
                cos_o <= x_rnd[XY_W-1:GUARD];
                sin_o <= y_rnd[XY_W-1:GUARD];
            end
        end
    end

    // R7: the folded start angle lies within a quarter turn
    a_r7_fold_range: assert property (@(posedge clk) disable iff (rst)
        load |-> (seed.z <= QUARTER_Z && seed.z >= -QUARTER_Z));

    // R6: the residual angle has converged when results are presented
    a_r6_residual_small: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (acc.z <= RES_TOL && acc.z >= -RES_TOL));

    // R6: the result vector has unit length within a small margin
    a_r6_unit_norm: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ((int'($signed(cos_o)) * int'($signed(cos_o))
                   + int'($signed(sin_o)) * int'($signed(sin_o))) >= (16384 - 64) * (16384 - 64)
                 && (int'($signed(cos_o)) * int'($signed(cos_o))
                   + int'($signed(sin_o)) * int'($signed(sin_o))) <= (16384 + 64) * (16384 + 64)));

    // R8: outputs only move together with the completion strobe
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (cos_o != $past(cos_o) || sin_o != $past(sin_o)) |-> done_o);
endmodule

// File: tb/cordic_rot_tb.sv
module cordic_rot_tb_top;
    localparam int NSTEP = 16;
    localparam int TOL   = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] angle_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [15:0] cos_o;
    logic [15:0] sin_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    string cur_tag = "R6";

    bit  m_busy = 0;
    bit  m_done = 0;
    int  m_cnt  = 0;
    int  m_ang  = 0;
    int  exp_c  = 0;
    int  exp_s  = 0;
    logic [15:0] prev_c = '0;
    logic [15:0] prev_s = '0;
    bit  armed = 0;

    cordic_rot dut_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .angle_i (angle_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .cos_o   (cos_o),
        .sin_o   (sin_o)
    );

    always #2.5 clk = ~clk;

    function automatic int rnd(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference: a cycle counter plus the math library
    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0;
            m_done = 0;
            m_cnt  = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_cnt == NSTEP - 1) begin
                    m_busy = 0;
                    m_done = 1;
                    exp_c = rnd($cos(real'(m_ang) * 3.14159265358979 / 32768.0) * 16384.0);
                    exp_s = rnd($sin(real'(m_ang) * 3.14159265358979 / 32768.0) * 16384.0);
                end else begin
                    m_cnt++;
                end
            end else if (start_i) begin
                m_busy = 1;
                m_cnt  = 0;
                m_ang  = int'($signed(angle_i));
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
        if (armed) begin
            chk(busy_o == m_busy, "R2 busy", busy_o, m_busy);
            chk(done_o == m_done, "R3 done", done_o, m_done);
            if (m_done) begin
                chk(($signed(cos_o) - exp_c) <= TOL && (exp_c - $signed(cos_o)) <= TOL,
                    {cur_tag, " cos"}, $signed(cos_o), exp_c);
                chk(($signed(sin_o) - exp_s) <= TOL && (exp_s - $signed(sin_o)) <= TOL,
                    {cur_tag, " sin"}, $signed(sin_o), exp_s);
            end else begin
                chk(cos_o == prev_c, "R8 cos hold", $signed(cos_o), $signed(prev_c));
                chk(sin_o == prev_s, "R8 sin hold", $signed(sin_o), $signed(prev_s));
            end
        end
        prev_c = cos_o;
        prev_s = sin_o;
    end

    task automatic wait_done();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done_o) break;
        end
        #1;
    endtask

    task automatic run_one(input int a);
        @(negedge clk);
        #1;
        angle_i = 16'(a);
        start_i = 1'b1;
        @(negedge clk);
        #1;
        start_i = 1'b0;
        wait_done();
    endtask

    initial begin
        int angs [14] = '{0, 8192, -8192, 16384, -16384, 16385, -16385,
                          24576, -24576, 32767, -32768, 1, 5461, -27307};
        repeat (3) @(negedge clk);
        // R1: reset state visible while reset is held
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags in reset", {busy_o, done_o}, 0);
        chk(cos_o == '0 && sin_o == '0, "R1 outputs in reset", cos_o, 0);
        #1;
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags after reset", {busy_o, done_o}, 0);
        chk(cos_o == '0 && sin_o == '0, "R1 outputs after reset", sin_o, 0);
        armed = 1;

        // R6 / R7: fixed corner angles, folded ones tagged R7
        foreach (angs[k]) begin
            cur_tag = (angs[k] > 16384 || angs[k] < -16384) ? "R7" : "R6";
            run_one(angs[k]);
        end

        // R6 / R7: sweep around the circle
        for (int k = 0; k < 24; k++) begin
            int a = k * 2731 - 32768;
            cur_tag = (a > 16384 || a < -16384) ? "R7" : "R6";
            run_one(a);
        end

        // R4: a second start while busy is ignored
        cur_tag = "R4";
        @(negedge clk);
        #1;
        angle_i = 16'(6000);
        start_i = 1'b1;
        @(negedge clk);
        #1;
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        angle_i = 16'(-20000);
        start_i = 1'b1;
        @(negedge clk);
        #1;
        start_i = 1'b0;
        wait_done();

        // R5: angle input changes during the run are ignored
        cur_tag = "R5";
        @(negedge clk);
        #1;
        angle_i = 16'(-12000);
        start_i = 1'b1;
        @(negedge clk);
        #1;
        start_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            #1;
            angle_i = 16'(i * 9000);
        end
        wait_done();

        // R4: start held through the done cycle is accepted back to back
        cur_tag = "R4";
        @(negedge clk);
        #1;
        angle_i = 16'(3000);
        start_i = 1'b1;
        @(negedge clk);
        #1;
        start_i = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (busy_o == 1'b0) break;
        end
        #1;
        angle_i = 16'(29000);
        start_i = 1'b1;
        @(negedge clk);
        #1;
        start_i = 1'b0;
        wait_done();

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule